// File: doc/BRIEF.md
# NAND Hamming ECC Generator

This block watches a byte stream as it passes across a byte-wide data interface and folds every accepted byte into a running parity state. From that state it forms a 24-bit Hamming-style check code. The code is enough to locate and repair any single flipped bit in its data block, or to flag that two bits flipped. A layout select picks one of two arrangements. In the split layout, two codes are formed, one per 256-byte block, and placed in two result slots in turn. In the whole layout, one code is formed over 512 bytes and only the first slot is used.

The stream side is valid/ready. A byte is accepted on a clock edge where `in_valid` and `in_ready` are both high. The block never applies back-pressure, so `in_ready` is always high. A producer may insert idle cycles at any point; idle cycles are not counted and do not disturb the state. Once the last slot of the chosen layout has been written, the results are frozen: accepted bytes are dropped until software pulses `rearm`. The `rearm` pulse clears both slots and both done flags, samples `layout_whole`, and restarts the byte count at the next accepted byte. Decoding and correction are left to software.

Top module: `nand_ecc_gen`

## Requirements
- R1: After reset, `ecc1`, `ecc2`, `done1` and `done2` are all zero, `in_ready` is high, and the split layout is in force.
- R2: In the split layout, the code of bytes 0..255 after a re-arm appears on `ecc1`, and `done1` rises on the clock edge that accepts byte 255.
- R3: In the split layout, the code of bytes 256..511 appears on `ecc2`, and `done2` rises on the edge that accepts byte 511; `done2` is never set while `done1` is clear.
- R4: In the whole layout, the code of bytes 0..511 appears on `ecc1` with `done1`; `ecc2` stays zero and `done2` stays low.
- R5: Split code format. Byte index i has bits i[7:0]; data bit j has bits j[2:0]. Line parity bit 2k+v is the XOR of every data bit of every byte whose index bit k equals v, for k = 0..7. Column parity bit 2c+v is the XOR of every data bit whose position bit c equals v, for c = 0..2. The code is the bitwise inverse of {column parity[5:0], 2'b00, line parity[15:0]}.
- R6: Whole code format: same rule with index bits i[8:0], giving 18 line parity bits. The code is the inverse of {column parity[5:0], line parity[17:0]}.
- R7: After the last slot of the chosen layout is written, further accepted bytes change neither slot nor either done flag until the next `rearm`.
- R8: A `rearm` pulse, whatever the data lines hold, clears both slots and both done flags and samples `layout_whole` (1 = whole, 0 = split). A byte offered in the same cycle as `rearm` is not counted.
- R9: Cycles with `in_valid` low contribute nothing: the codes depend only on the sequence of accepted bytes.
- R10: A block of all 0xFF bytes gives the code 24'hFFFFFF in either layout.
- R11: Flipping one data bit changes exactly one bit of every parity pair, and never bits 17:16 in the split layout. The odd member of each pair in the change spells out the byte index and the bit position of the flip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 8 | Stream byte |
| in_valid | input | 1 | Stream byte is offered |
| in_ready | output | 1 | Stream byte can be taken (always high) |
| layout_whole | input | 1 | Layout select sampled at `rearm`: 1 = one 512-byte code, 0 = two 256-byte codes |
| rearm | input | 1 | One-cycle pulse that clears the results and restarts the count |
| ecc1 | output | 24 | First result slot |
| ecc2 | output | 24 | Second result slot |
| done1 | output | 1 | First slot holds a finished code |
| done2 | output | 1 | Second slot holds a finished code |

## Verification
Random bytes with random idle gaps, in both layouts, check the parity folding against an independent bit-by-bit reference. The gaps also show that idle cycles do not shift the byte index. An erased all-0xFF block isolates the inversion and the tied bits. Two blocks that differ in one bit show that the line and column pairs locate the flip. Bytes sent after the last slot, and a byte offered alongside `rearm`, tell the freeze and re-arm rules apart from ordinary accumulation.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

  localparam int BYTE_W     = 8;
  localparam int POS_W      = 3;                    // bit-position index width within a byte
  localparam int COL_W      = 2 * POS_W;            // column parity bits
  localparam int SPLIT_IDX_W = 8;                   // byte index bits of a split block
  localparam int WHOLE_IDX_W = SPLIT_IDX_W + 1;     // byte index bits of a whole block
  localparam int CODE_W     = 2 * WHOLE_IDX_W + COL_W;
  localparam int NUM_SLOTS  = 2;

  typedef enum logic {
    LAYOUT_SPLIT = 1'b0,
    LAYOUT_WHOLE = 1'b1
  } layout_e;

  // Column parity from the XOR of all bytes of a block: pair c holds the
  // parity of bit positions whose bit c is 0 (even member) or 1 (odd member).
  function automatic logic [COL_W-1:0] fold_columns(input logic [BYTE_W-1:0] col);
    logic [COL_W-1:0] cp;
    cp = '0;
    for (int c = 0; c < POS_W; c++) begin
      for (int j = 0; j < BYTE_W; j++) begin
        if (((j >> c) & 1) != 0) cp[2*c+1] = cp[2*c+1] ^ col[j];
        else                     cp[2*c]   = cp[2*c]   ^ col[j];
      end
    end
    return cp;
  endfunction

endpackage

// File: rtl/nand_ecc_seq.sv
module nand_ecc_seq
  import nand_ecc_pkg::*;
#(
  parameter int IDX_W     = WHOLE_IDX_W,
  parameter int SPLIT_W   = SPLIT_IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             rearm,
  input  logic             layout_whole,
  output logic             take,
  output logic [IDX_W-1:0] idx,
  output layout_e          layout_q,
  output logic             blk_end,
  output logic             wr1,
  output logic             wr2,
  output logic             done1,
  output logic             done2
);

  localparam logic [IDX_W-1:0]   WHOLE_LAST = '1;
  localparam logic [SPLIT_W-1:0] SPLIT_LAST = '1;

  logic [IDX_W-1:0] cnt_q;
  logic             frozen;

  assign frozen  = (layout_q == LAYOUT_WHOLE) ? done1 : done2;
  assign take    = in_valid && !frozen && !rearm;
  assign idx     = cnt_q;
  assign blk_end = take && ((layout_q == LAYOUT_WHOLE) ? (cnt_q == WHOLE_LAST)
                                                       : (cnt_q[SPLIT_W-1:0] == SPLIT_LAST));
  assign wr1     = blk_end && !done1;
  assign wr2     = blk_end && done1 && (layout_q == LAYOUT_SPLIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      layout_q <= LAYOUT_SPLIT;
      done1    <= 1'b0;
      done2    <= 1'b0;
    end else if (rearm) begin
      cnt_q    <= '0;
      layout_q <= layout_whole ? LAYOUT_WHOLE : LAYOUT_SPLIT;
      done1    <= 1'b0;
      done2    <= 1'b0;
    end else if (take) begin
      cnt_q <= cnt_q + 1'b1;
      if (wr1) done1 <= 1'b1;
      if (wr2) done2 <= 1'b1;
    end
  end

endmodule

// File: rtl/nand_ecc_accum.sv
module nand_ecc_accum
  import nand_ecc_pkg::*;
#(
  parameter int IDX_W = WHOLE_IDX_W,
  parameter int DW    = BYTE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               take,
  input  logic [DW-1:0]      data,
  input  logic [IDX_W-1:0]   idx,
  output logic [DW-1:0]      col_nxt,
  output logic [2*IDX_W-1:0] line_nxt
);

  logic [DW-1:0]      col_q;
  logic [2*IDX_W-1:0] line_q;
  logic               byte_par;

  assign byte_par = ^data;

  // Each accepted byte toggles its column bits and, for every index bit,
  // the line parity member selected by that bit's value.
  always_comb begin
    col_nxt  = col_q;
    line_nxt = line_q;
    if (take) begin
      col_nxt = col_q ^ data;
      for (int k = 0; k < IDX_W; k++) begin
        if (idx[k]) line_nxt[2*k+1] = line_q[2*k+1] ^ byte_par;
        else        line_nxt[2*k]   = line_q[2*k]   ^ byte_par;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      line_q <= '0;
    end else if (clear) begin
      col_q  <= '0;
      line_q <= '0;
    end else if (take) begin
      col_q  <= col_nxt;
      line_q <= line_nxt;
    end
  end

endmodule

// File: rtl/nand_ecc_pack.sv
module nand_ecc_pack
  import nand_ecc_pkg::*;
#(
  parameter int IDX_W = WHOLE_IDX_W,
  parameter int DW    = BYTE_W,
  parameter int CW    = 2 * IDX_W + COL_W
) (
  input  layout_e            layout,
  input  logic [DW-1:0]      col,
  input  logic [2*IDX_W-1:0] line,
  output logic [CW-1:0]      code
);

  localparam int SPLIT_LINE_W = 2 * (IDX_W - 1);
  localparam int TIED_W       = CW - COL_W - SPLIT_LINE_W;

  logic [COL_W-1:0] cp;
  logic [CW-1:0]    raw;

  assign cp = fold_columns(col);

  always_comb begin
    if (layout == LAYOUT_WHOLE) raw = {cp, line};
    else                        raw = {cp, {TIED_W{1'b0}}, line[SPLIT_LINE_W-1:0]};
  end

  // Inverted so an erased block yields an all-ones code.
  assign code = ~raw;

endmodule

// File: rtl/nand_ecc_slots.sv
module nand_ecc_slots
  import nand_ecc_pkg::*;
#(
  parameter int CW    = CODE_W,
  parameter int SLOTS = NUM_SLOTS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clear,
  input  logic [SLOTS-1:0]          wr,
  input  logic [CW-1:0]             code,
  output logic [SLOTS-1:0][CW-1:0]  slot
);

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     slot[s] <= '0;
      else if (clear) slot[s] <= '0;
      else if (wr[s]) slot[s] <= code;
    end
  end

endmodule

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen
  import nand_ecc_pkg::*;
#(
  parameter int IDX_W = WHOLE_IDX_W,
  parameter int DW    = BYTE_W,
  parameter int CW    = 2 * IDX_W + COL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          layout_whole,
  input  logic          rearm,
  output logic [CW-1:0] ecc1,
  output logic [CW-1:0] ecc2,
  output logic          done1,
  output logic          done2
);

  logic               take;
  logic [IDX_W-1:0]   idx;
  layout_e            layout_q;
  logic               blk_end;
  logic               wr1;
  logic               wr2;
  logic [DW-1:0]      col_nxt;
  logic [2*IDX_W-1:0] line_nxt;
  logic [CW-1:0]      code;
  logic [NUM_SLOTS-1:0][CW-1:0] slot;

  assign in_ready = 1'b1;

  nand_ecc_seq #(.IDX_W(IDX_W), .SPLIT_W(IDX_W-1)) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .rearm(rearm),
    .layout_whole(layout_whole), .take(take), .idx(idx), .layout_q(layout_q),
    .blk_end(blk_end), .wr1(wr1), .wr2(wr2), .done1(done1), .done2(done2)
  );

  nand_ecc_accum #(.IDX_W(IDX_W), .DW(DW)) u_acc (
    .clk(clk), .rst_n(rst_n), .clear(blk_end || rearm), .take(take),
    .data(in_data), .idx(idx), .col_nxt(col_nxt), .line_nxt(line_nxt)
  );

  nand_ecc_pack #(.IDX_W(IDX_W), .DW(DW), .CW(CW)) u_pack (
    .layout(layout_q), .col(col_nxt), .line(line_nxt), .code(code)
  );

  nand_ecc_slots #(.CW(CW), .SLOTS(NUM_SLOTS)) u_slots (
    .clk(clk), .rst_n(rst_n), .clear(rearm), .wr({wr2, wr1}),
    .code(code), .slot(slot)
  );

  assign ecc1 = slot[0];
  assign ecc2 = slot[1];

endmodule

// File: rtl/nand_ecc_gen_chk.sv
module nand_ecc_gen_chk
  import nand_ecc_pkg::*;
#(
  parameter int CW = CODE_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          rearm,
  input layout_e       layout_q,
  input logic          done1,
  input logic          done2,
  input logic [CW-1:0] ecc1,
  input logic [CW-1:0] ecc2
);

  // R3
  slot_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done2 |-> done1);

  // R2
  done1_needs_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done1) |-> $past(in_valid));

  // R7
  slot1_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done1 && !rearm) |=> $stable(ecc1));

  // R7
  slot2_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done2 && !rearm) |=> ($stable(ecc2) && $stable(ecc1) && done2));

  // R8
  rearm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> (!done1 && !done2 && ecc1 == '0 && ecc2 == '0));

  // R4
  whole_slot2_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (layout_q == LAYOUT_WHOLE) |-> (!done2 && ecc2 == '0));

  // R5
  split_tied_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done1 && layout_q == LAYOUT_SPLIT) |-> (ecc1[17:16] == 2'b11));

  // R9
  idle_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !rearm) |=> ($stable(done1) && $stable(done2)));

endmodule

bind nand_ecc_gen nand_ecc_gen_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .rearm(rearm),
  .layout_q(layout_q), .done1(done1), .done2(done2), .ecc1(ecc1), .ecc2(ecc2)
);

// File: tb/tb_nand_ecc_gen.sv
`timescale 1ns/1ps
module tb_nand_ecc_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        layout_whole = 1'b0;
  logic        rearm = 1'b0;
  logic [23:0] ecc1, ecc2;
  logic        done1, done2;

  int vectors = 0;
  int misses  = 0;
  int cycles  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  nand_ecc_gen dut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .layout_whole(layout_whole), .rearm(rearm),
    .ecc1(ecc1), .ecc2(ecc2), .done1(done1), .done2(done2)
  );

  // ---------------- reference model ----------------
  logic [7:0]  blk[$];
  logic [23:0] m_e1 = '0, m_e2 = '0;
  bit          m_d1 = 0, m_d2 = 0, m_whole = 0;

  function automatic logic [23:0] ref_code(input bit whole);
    logic [17:0] lp;
    logic [5:0]  cp;
    int nidx;
    lp = '0; cp = '0;
    nidx = whole ? 9 : 8;
    for (int i = 0; i < blk.size(); i++) begin
      for (int j = 0; j < 8; j++) begin
        if (blk[i][j]) begin
          for (int k = 0; k < nidx; k++) lp[2*k + ((i >> k) & 1)] ^= 1'b1;
          for (int c = 0; c < 3; c++)    cp[2*c + ((j >> c) & 1)] ^= 1'b1;
        end
      end
    end
    if (whole) return ~{cp, lp};
    return ~{cp, 2'b00, lp[15:0]};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk.delete(); m_e1 = '0; m_e2 = '0; m_d1 = 0; m_d2 = 0; m_whole = 0;
    end else if (rearm) begin
      blk.delete(); m_e1 = '0; m_e2 = '0; m_d1 = 0; m_d2 = 0; m_whole = layout_whole;
    end else if (in_valid && !(m_whole ? m_d1 : m_d2)) begin
      blk.push_back(in_data);
      if (blk.size() == (m_whole ? 512 : 256)) begin
        if (!m_d1) begin m_e1 = ref_code(m_whole); m_d1 = 1; end
        else       begin m_e2 = ref_code(m_whole); m_d2 = 1; end
        blk.delete();
      end
    end
  end

  // ---------------- check helpers ----------------
  task automatic check24(input string req, input string what,
                         input logic [23:0] act, input logic [23:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check24("R2", "cycle ecc1", ecc1, m_e1);
      check24("R3", "cycle ecc2", ecc2, m_e2);
      check24("R7", "cycle done flags", {22'd0, done2, done1}, {22'd0, m_d2, m_d1});
      check24("R1", "cycle in_ready", {23'd0, in_ready}, 24'd1);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000 && !finished) begin
      finished = 1'b1;
      misses++;
      $display("FAIL R9 watchdog actual=%0d cycles expected=<150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic push(input logic [7:0] d, input bit gaps);
    @(negedge clk);
    if (gaps && $urandom_range(0, 3) == 0) begin
      in_valid = 1'b0;
      in_data  = 8'($urandom);
      @(negedge clk);
    end
    in_valid = 1'b1;
    in_data  = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = 8'($urandom);
    end
  endtask

  task automatic do_rearm(input bit whole);
    @(negedge clk);
    rearm = 1'b1; layout_whole = whole;
    in_valid = 1'b1; in_data = 8'h5A;   // offered with rearm: not counted (R8)
    @(negedge clk);
    rearm = 1'b0; in_valid = 1'b0;
  endtask

  logic [7:0] saved[256];
  logic [23:0] syn, held1, held2;
  int dec_idx, dec_pos;
  bit pairs_ok;

  initial begin
    idle(3);
    @(negedge clk);
    // R1: reset state
    check24("R1", "reset ecc1", ecc1, 24'h0);
    check24("R1", "reset ecc2", ecc2, 24'h0);
    check24("R1", "reset done", {22'd0, done2, done1}, 24'h0);
    rst_n = 1'b1;
    idle(2);

    // R2 R3 R5 R9: split layout, random data, random gaps, default layout from reset
    for (int i = 0; i < 512; i++) push(8'($urandom), 1'b1);
    idle(2);
    check24("R2", "split slot1 done", {23'd0, done1}, 24'd1);
    check24("R3", "split slot2 done", {23'd0, done2}, 24'd1);
    check24("R5", "split tied bits", {22'd0, ecc1[17:16]}, 24'd3);
    held1 = ecc1; held2 = ecc2;

    // R7: further data is ignored
    for (int i = 0; i < 300; i++) push(8'($urandom), 1'b0);
    idle(2);
    check24("R7", "frozen ecc1", ecc1, held1);
    check24("R7", "frozen ecc2", ecc2, held2);

    // R8: rearm clears, concurrent byte dropped; R9 long idle mid-block
    do_rearm(1'b0);
    check24("R8", "rearm ecc1", ecc1, 24'h0);
    check24("R8", "rearm done", {22'd0, done2, done1}, 24'h0);
    for (int i = 0; i < 255; i++) push(8'($urandom), 1'b1);
    idle(40);
    check24("R9", "idle keeps done1 low", {23'd0, done1}, 24'd0);
    push(8'($urandom), 1'b0);
    idle(2);
    check24("R9", "byte after idle completes slot1", {23'd0, done1}, 24'd1);

    // R4 R6: whole layout, rearm mid-block
    do_rearm(1'b1);
    for (int i = 0; i < 100; i++) push(8'($urandom), 1'b1);
    do_rearm(1'b1);
    for (int i = 0; i < 511; i++) push(8'($urandom), 1'b1);
    idle(2);
    check24("R4", "whole not done at 511", {23'd0, done1}, 24'd0);
    push(8'($urandom), 1'b0);
    idle(2);
    check24("R6", "whole slot1 done", {23'd0, done1}, 24'd1);
    for (int i = 0; i < 600; i++) push(8'($urandom), 1'b1);
    idle(2);
    check24("R4", "whole slot2 unused", ecc2, 24'h0);
    check24("R4", "whole done2 low", {23'd0, done2}, 24'd0);

    // R10: erased blocks in both layouts
    do_rearm(1'b0);
    for (int i = 0; i < 256; i++) push(8'hFF, 1'b0);
    idle(2);
    check24("R10", "erased split code", ecc1, 24'hFFFFFF);
    do_rearm(1'b1);
    for (int i = 0; i < 512; i++) push(8'hFF, 1'b1);
    idle(2);
    check24("R10", "erased whole code", ecc1, 24'hFFFFFF);

    // R11: single-bit flip at byte 77, bit 5
    do_rearm(1'b0);
    for (int i = 0; i < 256; i++) begin saved[i] = 8'($urandom); push(saved[i], 1'b1); end
    for (int i = 0; i < 256; i++) push((i == 77) ? (saved[i] ^ 8'h20) : saved[i], 1'b1);
    idle(2);
    syn = ecc1 ^ ecc2;
    pairs_ok = 1'b1;
    dec_idx = 0; dec_pos = 0;
    for (int k = 0; k < 8; k++) begin
      if ((syn[2*k] ^ syn[2*k+1]) != 1'b1) pairs_ok = 1'b0;
      dec_idx |= int'(syn[2*k+1]) << k;
    end
    for (int c = 0; c < 3; c++) begin
      if ((syn[18+2*c] ^ syn[19+2*c]) != 1'b1) pairs_ok = 1'b0;
      dec_pos |= int'(syn[19+2*c]) << c;
    end
    check24("R11", "every pair differs once", {23'd0, pairs_ok}, 24'd1);
    check24("R11", "tied bits unchanged", {22'd0, syn[17:16]}, 24'd0);
    check24("R11", "decoded byte index", 24'(dec_idx), 24'd77);
    check24("R11", "decoded bit position", 24'(dec_pos), 24'd5);

    idle(3);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule